// File: doc/BRIEF.md
# Paged Nonvolatile Store Command Controller

This block is a behavioural controller in front of an on-chip nonvolatile store. The store is split into four separately addressed regions: a 2048-byte code area, a 64-byte user signature area, a 32-byte factory signature area that cannot be changed, and a single 32-byte fuse row. The controller also keeps a small lock field. The regions are modelled in registers, and all of them share a 32-byte page.

A command is presented with `cmdValid` and is taken in the cycle `cmdReady` is high. It carries an operation, a region, a start address and a byte count minus one. Reads stream one byte per cycle on `rdValid`/`rdData`. Writes take one byte per accepted `wrValid` beat while `wrReady` is high. Every command ends with a one-cycle `done` pulse, and `err` is high in that same cycle if the command was refused. A burst never leaves its page, because the offset wraps at 32.

The erase rules depend on the region. Programming can only clear bits. A chip erase blanks the code and user signature areas and the lock field, but leaves the fuse row as it was. The fuse row can only be blanked by its own row erase, either as a plain page erase on the fuse region or as the first half of the rewrite operation. While any lock bit is programmed, the code area reads back as FFh and refuses writes and erases.

Top module: `nvm_cmd_top`

## Requirements
- R1: A read of N bytes (cmdLen = N-1, op code 0) from region r at address a returns, in order, the bytes at page-base(a) + ((a + i) mod 32) for i = 0..N-1. The last byte arrives in the same cycle as `done`.
- R2: A write (op code 1) leaves each addressed byte equal to its old value ANDed with the supplied data.
- R3: A write burst that passes offset 31 continues at offset 0 of the same page, and bytes in the next page are unchanged.
- R4: A page erase (op code 2) sets all 32 bytes of the addressed page to FFh and changes no other page.
- R5: A chip erase (op code 3) holds `busy` high and `cmdReady` low for exactly ERASE_CYCLES cycles, then pulses `done`. Afterwards all code and user signature bytes read FFh.
- R6: A chip erase leaves every fuse row byte unchanged.
- R7: A fuse rewrite (op code 4, region 3) first sets the whole fuse row to FFh and then programs the supplied bytes. Any other region with this op code is refused with `err`.
- R8: The factory signature region (region 2) reads byte k as 8'h5A XOR k. Any write or erase aimed at it is refused with `err` and changes nothing.
- R9: While `lockBits` is not all ones, code region (region 0) reads return FFh, and code writes or code page erases are refused with `err`. Other regions keep working.
- R10: A lock write (op code 5) ANDs `lockBits` with the low bits of `wrData` presented with the command. Only a chip erase returns `lockBits` to all ones; a fuse row erase does not.
- R11: The user signature region (region 1) uses only the low 6 address bits, so a higher address aliases onto the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; all storage blank, lock field all ones |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 3 | 0 read, 1 write, 2 page erase, 3 chip erase, 4 fuse rewrite, 5 lock write |
| cmdRegion | input | 2 | 0 code, 1 user signature, 2 factory signature, 3 fuse row |
| cmdAddr | input | 11 | Start byte address within the region |
| cmdLen | input | 5 | Byte count minus one |
| cmdReady | output | 1 | Controller idle and able to take a command |
| wrValid | input | 1 | Write data beat present |
| wrData | input | 8 | Write data; low bits also carry the lock write value |
| wrReady | output | 1 | Controller is taking write beats |
| rdValid | output | 1 | Read byte present |
| rdData | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Command refused; valid with `done` |
| busy | output | 1 | Chip erase in progress |
| lockBits | output | 2 | Lock field; all ones means unlocked |

## Verification
The bench aims at page wrap-around on both reads and writes. A design that carried the offset into the next page would corrupt the byte after the page and return the wrong order of bytes. Rewriting a byte checks that programming is an AND, which a design that overwrote would fail. Chip erase is checked against the fuse row and the lock field: a design that also erased the fuse row, or that left the lock set, would show the wrong read-back. The bench also checks that a fuse row erase does not unlock, and that commands aimed at the factory signature or at a locked code area come back with `err` and leave the stored bytes as they were.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int PAGE_BYTES = 32;
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int CODE_BYTES = 2048;
  localparam int ADDR_W     = $clog2(CODE_BYTES);

  typedef enum logic [2:0] {
    OP_READ         = 3'd0,
    OP_WRITE        = 3'd1,
    OP_PAGE_ERASE   = 3'd2,
    OP_CHIP_ERASE   = 3'd3,
    OP_FUSE_REWRITE = 3'd4,
    OP_LOCK         = 3'd5
  } nvmOp_e;

  typedef enum logic [1:0] {
    RG_CODE = 2'd0,
    RG_USIG = 2'd1,
    RG_FSIG = 2'd2,
    RG_FUSE = 2'd3
  } nvmRegion_e;

  typedef struct packed {
    logic               rdEn;
    logic               wrEn;
    logic               pageErase;
    logic               chipErase;
    logic               lockWr;
    nvmRegion_e         region;
    logic [ADDR_W-1:0]  addr;
  } nvmStrobe_t;
endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int USIG_BYTES   = 64,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [1:0]        cmdRegion,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [OFF_W-1:0]  cmdLen,
  output logic              cmdReady,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic              locked,
  output nvmStrobe_t        strobe,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_ERASE} ctrlState_e;

  ctrlState_e        state;
  nvmRegion_e        curRegion;
  logic [ADDR_W-1:0] pageBase;
  logic [OFF_W-1:0]  offset;
  logic [OFF_W-1:0]  remaining;
  logic [CNT_W-1:0]  eraseCnt;

  nvmOp_e            op;
  nvmRegion_e        rg;
  logic [ADDR_W-1:0] maskedAddr;
  logic              reject;

  assign op = nvmOp_e'(cmdOp);
  assign rg = nvmRegion_e'(cmdRegion);

  always_comb begin
    case (rg)
      RG_CODE: maskedAddr = cmdAddr;
      RG_USIG: maskedAddr = cmdAddr & ADDR_W'(USIG_BYTES - 1);
      default: maskedAddr = cmdAddr & ADDR_W'(PAGE_BYTES - 1);
    endcase
  end

  always_comb begin
    reject = 1'b0;
    case (op)
      OP_READ, OP_CHIP_ERASE, OP_LOCK: reject = 1'b0;
      OP_WRITE, OP_PAGE_ERASE:
        reject = (rg == RG_FSIG) || ((rg == RG_CODE) && locked);
      OP_FUSE_REWRITE: reject = (rg != RG_FUSE);
      default: reject = 1'b1;
    endcase
  end

  assign cmdReady = (state == ST_IDLE);
  assign wrReady  = (state == ST_WRITE);
  assign busy     = (state == ST_ERASE);

  always_comb begin
    strobe        = '0;
    strobe.region = curRegion;
    strobe.addr   = {pageBase[ADDR_W-1:OFF_W], offset};
    case (state)
      ST_IDLE: if (cmdValid && !reject) begin
        strobe.region = rg;
        strobe.addr   = maskedAddr;
        case (op)
          OP_PAGE_ERASE, OP_FUSE_REWRITE: strobe.pageErase = 1'b1;
          OP_CHIP_ERASE:                  strobe.chipErase = 1'b1;
          OP_LOCK:                        strobe.lockWr    = 1'b1;
          default: ;
        endcase
      end
      ST_READ:  strobe.rdEn = 1'b1;
      ST_WRITE: strobe.wrEn = wrValid;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curRegion <= RG_CODE;
      pageBase  <= '0;
      offset    <= '0;
      remaining <= '0;
      eraseCnt  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: if (cmdValid) begin
          curRegion <= rg;
          pageBase  <= maskedAddr;
          offset    <= cmdAddr[OFF_W-1:0];
          remaining <= cmdLen;
          if (reject) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            case (op)
              OP_READ:                   state <= ST_READ;
              OP_WRITE, OP_FUSE_REWRITE: state <= ST_WRITE;
              OP_CHIP_ERASE: begin
                state    <= ST_ERASE;
                eraseCnt <= CNT_W'(ERASE_CYCLES - 1);
              end
              default: done <= 1'b1;
            endcase
          end
        end
        ST_READ: begin
          offset    <= offset + 1'b1;
          remaining <= remaining - 1'b1;
          if (remaining == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_WRITE: if (wrValid) begin
          offset    <= offset + 1'b1;
          remaining <= remaining - 1'b1;
          if (remaining == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_ERASE: begin
          if (eraseCnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            eraseCnt <= eraseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: the datapath's lock state must block every code write strobe
  p_locked_code_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.region == RG_CODE) |-> !locked);

  // R5: a chip erase period ends only through a done pulse
  p_busy_ends_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy || done));

  // R1: read bytes and the write handshake never overlap
  p_no_mixed_stream_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdEn && wrReady));
endmodule

// File: rtl/nvm_data.sv
module nvm_data
  import nvm_pkg::*;
#(
  parameter int         USIG_BYTES = 64,
  parameter int         LOCK_BITS  = 2,
  parameter logic [7:0] FSIG_KEY   = 8'h5A
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nvmStrobe_t           strobe,
  input  logic [7:0]           wrData,
  output logic                 rdValid,
  output logic [7:0]           rdData,
  output logic                 locked,
  output logic [LOCK_BITS-1:0] lockBits
);
  localparam int USIG_W = $clog2(USIG_BYTES);

  logic [7:0] codeMem [CODE_BYTES];
  logic [7:0] usigMem [USIG_BYTES];
  logic [7:0] fuseMem [PAGE_BYTES];
  logic [LOCK_BITS-1:0] lockReg;

  logic [USIG_W-1:0] usigIdx;
  logic [OFF_W-1:0]  rowIdx;

  assign usigIdx  = strobe.addr[USIG_W-1:0];
  assign rowIdx   = strobe.addr[OFF_W-1:0];
  assign locked   = ~&lockReg;
  assign lockBits = lockReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CODE_BYTES; i++) codeMem[i] <= 8'hFF;
      for (int i = 0; i < USIG_BYTES; i++) usigMem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) fuseMem[i] <= 8'hFF;
      lockReg <= '1;
      rdValid <= 1'b0;
      rdData  <= 8'hFF;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) begin
        case (strobe.region)
          RG_CODE: rdData <= locked ? 8'hFF : codeMem[strobe.addr];
          RG_USIG: rdData <= usigMem[usigIdx];
          RG_FSIG: rdData <= FSIG_KEY ^ {{(8-OFF_W){1'b0}}, rowIdx};
          default: rdData <= fuseMem[rowIdx];
        endcase
      end
      if (strobe.wrEn) begin
        case (strobe.region)
          RG_CODE: codeMem[strobe.addr] <= codeMem[strobe.addr] & wrData;
          RG_USIG: usigMem[usigIdx] <= usigMem[usigIdx] & wrData;
          RG_FUSE: fuseMem[rowIdx] <= fuseMem[rowIdx] & wrData;
          default: ;
        endcase
      end
      if (strobe.pageErase) begin
        for (int k = 0; k < PAGE_BYTES; k++) begin
          case (strobe.region)
            RG_CODE: codeMem[{strobe.addr[ADDR_W-1:OFF_W], OFF_W'(k)}] <= 8'hFF;
            RG_USIG: usigMem[{usigIdx[USIG_W-1:OFF_W], OFF_W'(k)}] <= 8'hFF;
            RG_FUSE: fuseMem[k] <= 8'hFF;
            default: ;
          endcase
        end
      end
      if (strobe.chipErase) begin
        for (int i = 0; i < CODE_BYTES; i++) codeMem[i] <= 8'hFF;
        for (int i = 0; i < USIG_BYTES; i++) usigMem[i] <= 8'hFF;
        lockReg <= '1;
      end else if (strobe.lockWr) begin
        lockReg <= lockReg & wrData[LOCK_BITS-1:0];
      end
    end
  end

  // R8: no write strobe ever reaches the factory signature region
  p_fsig_untouched_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (strobe.region != RG_FSIG));

  // R10: the control's chip erase strobe leaves the store unlocked
  p_chip_unlocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.chipErase |=> !locked);

  // R6: fuse row survives chip erase
  p_fuse_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.chipErase |=> ($stable(fuseMem[0]) && $stable(fuseMem[PAGE_BYTES-1])));
endmodule

// File: rtl/nvm_cmd_top.sv
module nvm_cmd_top
  import nvm_pkg::*;
#(
  parameter int         USIG_BYTES   = 64,
  parameter int         LOCK_BITS    = 2,
  parameter int         ERASE_CYCLES = 16,
  parameter logic [7:0] FSIG_KEY     = 8'h5A
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [1:0]           cmdRegion,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [OFF_W-1:0]     cmdLen,
  output logic                 cmdReady,
  input  logic                 wrValid,
  input  logic [7:0]           wrData,
  output logic                 wrReady,
  output logic                 rdValid,
  output logic [7:0]           rdData,
  output logic                 done,
  output logic                 err,
  output logic                 busy,
  output logic [LOCK_BITS-1:0] lockBits
);
  nvmStrobe_t strobe;
  logic       locked;

  nvm_ctrl #(
    .USIG_BYTES  (USIG_BYTES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdRegion(cmdRegion),
    .cmdAddr  (cmdAddr),
    .cmdLen   (cmdLen),
    .cmdReady (cmdReady),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .locked   (locked),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  nvm_data #(
    .USIG_BYTES(USIG_BYTES),
    .LOCK_BITS (LOCK_BITS),
    .FSIG_KEY  (FSIG_KEY)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .rdValid (rdValid),
    .rdData  (rdData),
    .locked  (locked),
    .lockBits(lockBits)
  );
endmodule

// File: tb/tb_nvm_cmd_top.sv
module tb_nvm_cmd_top;
  localparam int ERASE_CYCLES = 16;
  localparam int CODE_BYTES   = 2048;
  localparam int USIG_BYTES   = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [1:0]  cmdRegion = '0;
  logic [10:0] cmdAddr = '0;
  logic [4:0]  cmdLen = '0;
  logic        cmdReady;
  logic        wrValid = 1'b0;
  logic [7:0]  wrData = '0;
  logic        wrReady;
  logic        rdValid;
  logic [7:0]  rdData;
  logic        done;
  logic        err;
  logic        busy;
  logic [1:0]  lockBits;

  nvm_cmd_top #(.ERASE_CYCLES(ERASE_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdRegion(cmdRegion), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .cmdReady(cmdReady), .wrValid(wrValid), .wrData(wrData),
    .wrReady(wrReady), .rdValid(rdValid), .rdData(rdData), .done(done),
    .err(err), .busy(busy), .lockBits(lockBits)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0] codeM [CODE_BYTES];
  logic [7:0] usigM [USIG_BYTES];
  logic [7:0] fuseM [32];
  logic [1:0] lockM;
  logic [7:0] wbuf [32];
  logic [7:0] rdQ [$];
  int         doneCnt = 0;
  int         busyCnt = 0;
  logic       lastErr = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rdValid) rdQ.push_back(rdData);
    if (busy) busyCnt++;
    if (busy && cmdReady) check(1'b0, "R5 ready during busy", 1, 0);
    if (done) begin
      lastErr = err;
      doneCnt++;
    end
  end

  function automatic int fullAddr(input int rg, input int a, input int i);
    int m;
    m = (rg == 0) ? CODE_BYTES - 1 : (rg == 1) ? USIG_BYTES - 1 : 31;
    return ((a & m) & ~31) | ((a + i) & 31);
  endfunction

  function automatic logic [7:0] expByte(input int rg, input int fa);
    case (rg)
      0: return (lockM != 2'b11) ? 8'hFF : codeM[fa];
      1: return usigM[fa];
      2: return 8'h5A ^ 8'(fa);
      default: return fuseM[fa];
    endcase
  endfunction

  task automatic issue(input int op, input int rg, input int a, input int len, input logic [7:0] wd);
    int start;
    start = doneCnt;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdRegion = 2'(rg);
    cmdAddr = 11'(a); cmdLen = 5'(len - 1); wrData = wd;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    if (op == 1 || op == 4) begin
      for (int i = 0; i < len; i++) begin
        if (!wrReady) break;
        wrValid = 1'b1; wrData = wbuf[i];
        @(negedge clk);
      end
      wrValid = 1'b0;
    end
    wait (doneCnt > start);
  endtask

  task automatic doRead(input int rg, input int a, input int len, input string req);
    rdQ.delete();
    issue(0, rg, a, len, 8'h00);
    check(rdQ.size() == len, {req, " read count"}, rdQ.size(), len);
    for (int i = 0; i < len && i < rdQ.size(); i++) begin
      logic [7:0] e;
      e = expByte(rg, fullAddr(rg, a, i));
      check(rdQ[i] == e, req, rdQ[i], e);
    end
  endtask

  task automatic doWrite(input int rg, input int a, input int len, input bit expErr, input string req);
    issue(1, rg, a, len, 8'h00);
    check(lastErr == expErr, {req, " err"}, lastErr, expErr);
    if (!expErr)
      for (int i = 0; i < len; i++) begin
        int fa;
        fa = fullAddr(rg, a, i);
        case (rg)
          0: codeM[fa] = codeM[fa] & wbuf[i];
          1: usigM[fa] = usigM[fa] & wbuf[i];
          3: fuseM[fa] = fuseM[fa] & wbuf[i];
          default: ;
        endcase
      end
  endtask

  initial begin
    #(20ns * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    for (int i = 0; i < CODE_BYTES; i++) codeM[i] = 8'hFF;
    for (int i = 0; i < USIG_BYTES; i++) usigM[i] = 8'hFF;
    for (int i = 0; i < 32; i++) fuseM[i] = 8'hFF;
    lockM = 2'b11;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b1, "reset cmdReady", cmdReady, 1);
    check(busy == 1'b0 && done == 1'b0, "reset busy/done", {busy, done}, 0);
    check(lockBits == 2'b11, "R10 reset lockBits", lockBits, 3);

    // R1 blank read
    doRead(0, 11'h000, 8, "R1 blank code");

    // R2 write then AND-program
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hC3 + i * 8'h11);
    doWrite(0, 11'h044, 4, 1'b0, "R2 first write");
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h0F;
    doWrite(0, 11'h044, 4, 1'b0, "R2 second write");
    doRead(0, 11'h044, 4, "R2 AND result");
    check(codeM[11'h044] == 8'h03, "R2 model", codeM[11'h044], 8'h03);

    // R3 wrap on write, next page untouched; R1 wrapped read
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h10 + i);
    doWrite(0, 11'h05E, 4, 1'b0, "R3 wrap write");
    doRead(0, 11'h05E, 4, "R1 wrapped read");
    doRead(0, 11'h060, 2, "R3 next page");
    check(codeM[11'h040] == 8'h12, "R3 wrapped byte", codeM[11'h040], 8'h12);

    // R4 page erase only its page
    for (int i = 0; i < 2; i++) wbuf[i] = 8'h5C;
    doWrite(0, 11'h020, 2, 1'b0, "R4 neighbour write");
    issue(2, 0, 11'h047, 1, 8'h00);
    check(lastErr == 1'b0, "R4 erase err", lastErr, 0);
    for (int i = 0; i < 32; i++) codeM[11'h040 + i] = 8'hFF;
    doRead(0, 11'h040, 32, "R4 erased page");
    doRead(0, 11'h020, 2, "R4 neighbour kept");

    // R11 user signature alias
    wbuf[0] = 8'h81;
    doWrite(1, 11'h045, 1, 1'b0, "R11 aliased write");
    doRead(1, 11'h005, 1, "R11 alias read");

    // random code/usig traffic
    for (int n = 0; n < 60; n++) begin
      int rg, a, len;
      rg  = $urandom_range(1, 0);
      a   = $urandom_range(CODE_BYTES - 1, 0);
      len = $urandom_range(8, 1);
      if ($urandom_range(1, 0) == 1) begin
        for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
        doWrite(rg, a, len, 1'b0, "R2 random write");
      end else begin
        doRead(rg, a, len, "R1 random read");
      end
    end

    // R8 factory signature
    doRead(2, 11'h000, 32, "R8 fsig read");
    wbuf[0] = 8'h00;
    doWrite(2, 11'h003, 1, 1'b1, "R8 fsig write");
    issue(2, 2, 11'h000, 1, 8'h00);
    check(lastErr == 1'b1, "R8 fsig erase err", lastErr, 1);
    doRead(2, 11'h000, 8, "R8 fsig unchanged");

    // R7 fuse row
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h00;
    doWrite(3, 11'h000, 4, 1'b0, "R7 fuse enable");
    issue(4, 0, 11'h000, 1, 8'h00);
    check(lastErr == 1'b1, "R7 rewrite wrong region", lastErr, 1);
    wbuf[0] = 8'h00; wbuf[1] = 8'h3C;
    issue(4, 3, 11'h005, 2, 8'h00);
    check(lastErr == 1'b0, "R7 rewrite err", lastErr, 0);
    for (int i = 0; i < 32; i++) fuseM[i] = 8'hFF;
    fuseM[5] = 8'h00; fuseM[6] = 8'h3C;
    doRead(3, 11'h000, 32, "R7 fuse row");

    // R10 lock write, R9 locked behaviour
    issue(5, 0, 0, 1, 8'hFE);
    lockM = 2'b10;
    check(lockBits == 2'b10, "R10 lock write", lockBits, 2);
    doRead(0, 11'h020, 4, "R9 locked read");
    wbuf[0] = 8'h00;
    doWrite(0, 11'h020, 1, 1'b1, "R9 locked write");
    issue(2, 0, 11'h020, 1, 8'h00);
    check(lastErr == 1'b1, "R9 locked erase err", lastErr, 1);
    wbuf[0] = 8'h7E;
    doWrite(1, 11'h010, 1, 1'b0, "R9 usig while locked");
    doRead(1, 11'h010, 1, "R9 usig read locked");
    issue(2, 3, 11'h000, 1, 8'h00);
    for (int i = 0; i < 32; i++) fuseM[i] = 8'hFF;
    check(lockBits == 2'b10, "R10 fuse erase keeps lock", lockBits, 2);
    wbuf[0] = 8'h00; wbuf[1] = 8'hA0;
    doWrite(3, 11'h008, 2, 1'b0, "R6 fuse setup");

    // R5 R6 chip erase
    busyCnt = 0;
    issue(3, 0, 0, 1, 8'h00);
    check(busyCnt == ERASE_CYCLES, "R5 busy length", busyCnt, ERASE_CYCLES);
    check(lockBits == 2'b11, "R10 chip erase unlocks", lockBits, 3);
    lockM = 2'b11;
    for (int i = 0; i < CODE_BYTES; i++) codeM[i] = 8'hFF;
    for (int i = 0; i < USIG_BYTES; i++) usigM[i] = 8'hFF;
    doRead(0, 11'h020, 32, "R5 code blank");
    doRead(1, 11'h000, 32, "R5 usig blank");
    doRead(3, 11'h000, 32, "R6 fuse kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule